// File: doc/BRIEF.md
# Quadrature tracking position counter

This block turns the two phase signals of an incremental encoder into a synchronous count enable and a direction bit, and it keeps a signed position count. Both raw phase inputs are first registered through a two-stage synchronizer. A two-bit tracking state then follows the synchronized pair. Each clock, the block compares the new phase with the tracking state and sorts it into one of four step kinds: hold, one step up, one step down, or a two-step jump. It counts phase states, not edges. Chatter on one input while the other is steady therefore produces matching up and down steps, and these cancel.

A two-step jump means the clock was too slow to see an intermediate phase. This is never counted. The tracking state is reloaded from the input, and a sticky lost-sync flag is raised. A mode input selects four, two or one counts per full encoder cycle. A narrow host reads the 32-bit count by first strobing a snapshot, which copies every bit in one clock. It then selects the low or high half of that snapshot.

Top module: `quad_track_counter`

## Requirements
- R1: While reset is asserted, and after reset until the first step, the outputs are as follows: count_en 0, count_dir 0, lost_sync 0, rd_word 0. The position and snapshot are 0 and the tracking phase is {A,B}=00.
- R2: Each phase input passes through two synchronizer registers, and the outputs are registered. A single legal step applied to enc_a/enc_b shows as count_en high on the third rising edge after the change, for exactly one clock.
- R3: The forward phase order of {A,B} is 00, 01, 11, 10, then back to 00. A forward step counts up (count_dir 1, position +1). A backward step counts down (count_dir 0, position -1). A phase equal to the tracking phase gives no enable.
- R4: Toggling one input while the other is steady gives alternating up and down steps. After an even number of toggles the position is unchanged.
- R5: A jump to the opposite phase (00/11 or 01/10) gives no enable and leaves the position unchanged. It reloads the tracking phase from the input and sets lost_sync. lost_sync stays set until clr.
- R6: cfg_mode 00 or 11 counts every legal step. Mode 01 counts an up step that enters phase 00 or 11, and a down step that leaves phase 00 or 11 (two counts per cycle). Mode 10 does the same for phase 00 only (one count per cycle). count_dir follows every legal step in all modes.
- R7: clr is synchronous and takes priority over counting. It zeroes the position, clears lost_sync, loads the tracking phase from the synchronized input, and gives no enable in that clock.
- R8: The position is a 32-bit two's-complement value that wraps. One step down from 0 gives 0xFFFFFFFF.
- R9: snap_req copies all 32 position bits into the snapshot in one clock. rd_word shows snapshot bits 15:0 when word_sel is 0 and bits 31:16 when word_sel is 1. The snapshot does not change until the next snap_req.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_a | input | 1 | Raw phase A (MSB of the phase pair) |
| enc_b | input | 1 | Raw phase B (LSB of the phase pair) |
| cfg_mode | input | 2 | Counts per cycle: 00/11 four, 01 two, 10 one |
| clr | input | 1 | Synchronous clear of position and lost_sync |
| snap_req | input | 1 | Copy the position into the snapshot |
| word_sel | input | 1 | Snapshot half select: 0 low, 1 high |
| count_en | output | 1 | One-clock count pulse |
| count_dir | output | 1 | Sense of the latest legal step, 1 = up |
| lost_sync | output | 1 | Sticky two-step jump flag |
| rd_word | output | 16 | Selected half of the snapshot |

## Verification
The hardest case to reach from the ports is a snapshot that holds while the live count carries across the boundary between the low and high words. Counting up through 65536 steps is too slow. Instead, the stimulus clears the count and steps backward through zero, which flips all 32 bits. It snapshots the result and then counts forward, so that the live value crosses zero again. Both halves are then read without a new strobe. The boundary rules of the reduced modes are also exercised, by chattering across phase 00 in one-count mode.

// File: rtl/quad_pkg.sv
package quad_pkg;

    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_11 = 2'b11,
        PH_10 = 2'b10
    } phase_t;

    typedef enum logic [1:0] {
        STEP_HOLD,
        STEP_UP,
        STEP_DN,
        STEP_JUMP
    } step_t;

    typedef enum logic [1:0] {
        MODE_X4     = 2'b00,
        MODE_X2     = 2'b01,
        MODE_X1     = 2'b10,
        MODE_X4_ALT = 2'b11
    } mode_t;

    // True when a phase is a counting boundary in the given mode.
    function automatic logic on_boundary(phase_t ph, mode_t m);
        logic r;
        unique case (m)
            MODE_X2:     r = (ph == PH_00) || (ph == PH_11);
            MODE_X1:     r = (ph == PH_00);
            MODE_X4,
            MODE_X4_ALT: r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/quad_sync.sv
module quad_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/quad_phase_fsm.sv
module quad_phase_fsm
    import quad_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_t in_ph,
    output phase_t trk,
    output step_t  step
);

    phase_t trk_nxt;

    // State register: the tracking phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk <= PH_00;
        else        trk <= trk_nxt;
    end

    // Step classification and next phase
    always_comb begin
        step = STEP_JUMP;
        unique case (trk)
            PH_00: unique case (in_ph)
                PH_00: step = STEP_HOLD;
                PH_01: step = STEP_UP;
                PH_10: step = STEP_DN;
                PH_11: step = STEP_JUMP;
            endcase
            PH_01: unique case (in_ph)
                PH_01: step = STEP_HOLD;
                PH_11: step = STEP_UP;
                PH_00: step = STEP_DN;
                PH_10: step = STEP_JUMP;
            endcase
            PH_11: unique case (in_ph)
                PH_11: step = STEP_HOLD;
                PH_10: step = STEP_UP;
                PH_01: step = STEP_DN;
                PH_00: step = STEP_JUMP;
            endcase
            PH_10: unique case (in_ph)
                PH_10: step = STEP_HOLD;
                PH_00: step = STEP_UP;
                PH_11: step = STEP_DN;
                PH_01: step = STEP_JUMP;
            endcase
        endcase
        // Legal steps move to the input, a jump reloads it, a clear
        // loads it: in every case the next phase is the input.
        trk_nxt = in_ph;
    end

endmodule

// File: rtl/quad_position.sv
module quad_position
    import quad_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int WORD_W = 16,
    localparam int N_WORDS = CNT_W / WORD_W,
    localparam int SEL_W   = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              snap_req,
    input  logic [SEL_W-1:0]  word_sel,
    input  step_t             step,
    input  phase_t            old_ph,
    input  phase_t            new_ph,
    input  mode_t             mode,
    output logic              count_en,
    output logic              count_dir,
    output logic              lost_sync,
    output logic [CNT_W-1:0]  pos_q,
    output logic [CNT_W-1:0]  snap_q,
    output logic [WORD_W-1:0] rd_word
);

    logic hit;

    always_comb begin
        unique case (step)
            STEP_UP:   hit = on_boundary(new_ph, mode);
            STEP_DN:   hit = on_boundary(old_ph, mode);
            STEP_HOLD,
            STEP_JUMP: hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q     <= '0;
            snap_q    <= '0;
            count_en  <= 1'b0;
            count_dir <= 1'b0;
            lost_sync <= 1'b0;
        end else begin
            if (snap_req) snap_q <= pos_q;
            if (clr) begin
                pos_q     <= '0;
                count_en  <= 1'b0;
                lost_sync <= 1'b0;
            end else begin
                count_en <= hit;
                if (hit) begin
                    pos_q <= (step == STEP_UP) ? pos_q + CNT_W'(1)
                                               : pos_q - CNT_W'(1);
                end
                if (step == STEP_UP || step == STEP_DN) begin
                    count_dir <= (step == STEP_UP);
                end
                if (step == STEP_JUMP) lost_sync <= 1'b1;
            end
        end
    end

    assign rd_word = snap_q[int'(word_sel) * WORD_W +: WORD_W];

endmodule

// File: rtl/quad_track_counter.sv
module quad_track_counter
    import quad_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic [1:0]        cfg_mode,
    input  logic              clr,
    input  logic              snap_req,
    input  logic              word_sel,
    output logic              count_en,
    output logic              count_dir,
    output logic              lost_sync,
    output logic [WORD_W-1:0] rd_word
);

    logic [1:0]       sync_ab;
    phase_t           trk_ph;
    step_t            step_w;
    logic [CNT_W-1:0] pos_w;
    logic [CNT_W-1:0] snap_w;

    quad_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({enc_a, enc_b}),
        .dout (sync_ab)
    );

    quad_phase_fsm u_fsm (
        .clk  (clk),
        .rst_n(rst_n),
        .in_ph(phase_t'(sync_ab)),
        .trk  (trk_ph),
        .step (step_w)
    );

    quad_position #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .snap_req (snap_req),
        .word_sel (word_sel),
        .step     (step_w),
        .old_ph   (trk_ph),
        .new_ph   (phase_t'(sync_ab)),
        .mode     (mode_t'(cfg_mode)),
        .count_en (count_en),
        .count_dir(count_dir),
        .lost_sync(lost_sync),
        .pos_q    (pos_w),
        .snap_q   (snap_w),
        .rd_word  (rd_word)
    );

endmodule

// File: rtl/quad_track_checks.sv
module quad_track_checks
    import quad_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             snap_req,
    input logic             count_en,
    input logic             count_dir,
    input logic             lost_sync,
    input step_t            step,
    input logic [CNT_W-1:0] pos,
    input logic [CNT_W-1:0] snap
);

    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lost_sync && !clr |=> lost_sync);

    a_r5_jump_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        step == STEP_JUMP && !clr |=> lost_sync && !count_en && $stable(pos));

    a_r3_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        step == STEP_HOLD && !clr |=> !count_en && $stable(pos));

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !lost_sync && !count_en && pos == '0);

    a_r8_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        count_en && count_dir |-> pos == $past(pos) + CNT_W'(1));

    a_r8_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        count_en && !count_dir |-> pos == $past(pos) - CNT_W'(1));

    a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |=> snap == $past(pos));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> $stable(snap));

endmodule

bind quad_track_counter quad_track_checks #(.CNT_W(CNT_W)) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .snap_req (snap_req),
    .count_en (count_en),
    .count_dir(count_dir),
    .lost_sync(lost_sync),
    .step     (step_w),
    .pos      (pos_w),
    .snap     (snap_w)
);

// File: tb/test_quad_track_counter.sv
`timescale 1ns/1ps
module test_quad_track_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_a = 1'b0, enc_b = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic        clr = 1'b0, snap_req = 1'b0, word_sel = 1'b0;
    logic        count_en, count_dir, lost_sync;
    logic [15:0] rd_word;

    int checks = 0;
    int failures = 0;
    bit cmp_on = 1'b0;
    bit finished = 1'b0;
    int cur = 0;

    always #2 clk = ~clk;

    quad_track_counter i_quad_track_counter (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .cfg_mode(cfg_mode), .clr(clr), .snap_req(snap_req),
        .word_sel(word_sel), .count_en(count_en), .count_dir(count_dir),
        .lost_sync(lost_sync), .rd_word(rd_word)
    );

    // ---------------- reference model ----------------
    logic [1:0]  m_s1 = 2'b00, m_s2 = 2'b00;
    int          m_trk = 0;
    logic [31:0] m_pos = '0, m_snap = '0;
    logic        m_en = 1'b0, m_dir = 1'b0, m_err = 1'b0;

    function automatic int idx_of(logic [1:0] v);
        case (v)
            2'b00: return 0;
            2'b01: return 1;
            2'b11: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic [1:0] ph_of(int i);
        case (i % 4)
            0: return 2'b00;
            1: return 2'b01;
            2: return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    function automatic bit counts_at(int i, logic [1:0] m);
        if (m == 2'b01) return (i % 2) == 0;
        if (m == 2'b10) return i == 0;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 2'b00; m_s2 = 2'b00; m_trk = 0;
            m_pos = '0; m_snap = '0; m_en = 0; m_dir = 0; m_err = 0;
        end else begin
            int  d;
            int  ni;
            bit  up, dn, cnt;
            ni = idx_of(m_s2);
            d  = (ni - m_trk + 4) % 4;
            up = (d == 1);
            dn = (d == 3);
            if (snap_req) m_snap = m_pos;
            if (clr) begin
                m_pos = '0; m_err = 0; m_en = 0;
            end else begin
                cnt  = (up && counts_at(ni, cfg_mode)) || (dn && counts_at(m_trk, cfg_mode));
                m_en = cnt;
                if (cnt) m_pos = up ? m_pos + 32'd1 : m_pos - 32'd1;
                if (up || dn) m_dir = up;
                if (d == 2) m_err = 1'b1;
            end
            m_trk = ni;
            m_s2 = m_s1;
            m_s1 = {enc_a, enc_b};
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", what, act, exp, $time);
        end
    endtask

    // Compare against the model after every rising edge
    always begin
        @(posedge clk);
        #1;
        if (rst_n && cmp_on && !finished) begin
            chk("R2 count_en", {31'd0, count_en}, {31'd0, m_en});
            chk("R3 count_dir", {31'd0, count_dir}, {31'd0, m_dir});
            chk("R5 lost_sync", {31'd0, lost_sync}, {31'd0, m_err});
            chk("R9 rd_word", {16'd0, rd_word},
                {16'd0, word_sel ? m_snap[31:16] : m_snap[15:0]});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic drive(int i, int hold);
        @(negedge clk);
        {enc_a, enc_b} = ph_of(i);
        repeat (hold - 1) @(negedge clk);
    endtask

    task automatic go(int n, bit fwd, int hold);
        for (int k = 0; k < n; k++) begin
            cur = fwd ? (cur + 1) % 4 : (cur + 3) % 4;
            drive(cur, hold);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic do_clr();
        settle();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
    endtask

    task automatic read_held(output logic [31:0] v);
        @(negedge clk) word_sel = 1'b0;
        @(posedge clk) #1 v[15:0] = rd_word;
        @(negedge clk) word_sel = 1'b1;
        @(posedge clk) #1 v[31:16] = rd_word;
        @(negedge clk) word_sel = 1'b0;
    endtask

    task automatic read_pos(output logic [31:0] v);
        settle();
        @(negedge clk) snap_req = 1'b1;
        @(negedge clk) snap_req = 1'b0;
        read_held(v);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 count_en", {31'd0, count_en}, 32'd0);
        chk("R1 count_dir", {31'd0, count_dir}, 32'd0);
        chk("R1 lost_sync", {31'd0, lost_sync}, 32'd0);
        chk("R1 rd_word", {16'd0, rd_word}, 32'd0);
        @(negedge clk) rst_n = 1'b1;
        cmp_on = 1'b1;
        settle();
        chk("R1 no count after reset", {31'd0, count_en}, 32'd0);

        // R2 latency of a single step
        @(negedge clk) {enc_a, enc_b} = 2'b01;
        cur = 1;
        @(posedge clk) #1 chk("R2 edge1", {31'd0, count_en}, 32'd0);
        @(posedge clk) #1 chk("R2 edge2", {31'd0, count_en}, 32'd0);
        @(posedge clk) #1 chk("R2 edge3", {31'd0, count_en}, 32'd1);
        @(posedge clk) #1 chk("R2 edge4", {31'd0, count_en}, 32'd0);

        // R3 forward and reverse, four counts per cycle
        go(11, 1'b1, 3);
        read_pos(v);
        chk("R3 forward position", v, 32'd12);
        chk("R3 dir up", {31'd0, count_dir}, 32'd1);
        go(5, 1'b0, 3);
        read_pos(v);
        chk("R3 reverse position", v, 32'd7);
        chk("R3 dir down", {31'd0, count_dir}, 32'd0);

        // R4 chatter on B while A steady (10 <-> 11)
        for (int k = 0; k < 10; k++) begin
            cur = (k % 2 == 0) ? 2 : 3;
            drive(cur, 1);
        end
        read_pos(v);
        chk("R4 chatter cancels", v, 32'd7);

        // R7 clear, R8 wrap below zero
        do_clr();
        read_pos(v);
        chk("R7 clear zeroes position", v, 32'd0);
        go(3, 1'b0, 3);
        read_pos(v);
        chk("R8 wrap low word", {16'd0, v[15:0]}, 32'h0000FFFD);
        chk("R8 wrap high word", {16'd0, v[31:16]}, 32'h0000FFFF);

        // R9 snapshot holds while the live count crosses zero
        go(5, 1'b1, 3);
        settle();
        read_held(v);
        chk("R9 held snapshot", v, 32'hFFFFFFFD);
        read_pos(v);
        chk("R9 new snapshot", v, 32'd2);

        // R5 two-step jump
        cur = (cur + 2) % 4;
        drive(cur, 5);
        chk("R5 lost_sync set", {31'd0, lost_sync}, 32'd1);
        read_pos(v);
        chk("R5 jump not counted", v, 32'd2);
        go(2, 1'b1, 3);
        read_pos(v);
        chk("R5 counts after jump", v, 32'd4);
        chk("R5 sticky", {31'd0, lost_sync}, 32'd1);
        do_clr();
        settle();
        chk("R7 clear drops lost_sync", {31'd0, lost_sync}, 32'd0);

        // R6 two counts per cycle
        @(negedge clk) cfg_mode = 2'b01;
        go(8, 1'b1, 3);
        read_pos(v);
        chk("R6 x2 forward", v, 32'd4);
        go(4, 1'b0, 3);
        read_pos(v);
        chk("R6 x2 reverse", v, 32'd2);

        // R6 one count per cycle, then chatter across phase 00
        @(negedge clk) cfg_mode = 2'b10;
        do_clr();
        go(12, 1'b1, 3);
        read_pos(v);
        chk("R6 x1 forward", v, 32'd3);
        while (cur != 0) go(1, 1'b0, 3);
        read_pos(v);
        chk("R6 x1 approach", v, 32'd3);
        for (int k = 0; k < 6; k++) begin
            cur = (k % 2 == 0) ? 3 : 0;
            drive(cur, 1);
        end
        read_pos(v);
        chk("R6 R4 x1 chatter across 00", v, 32'd3);

        // R6 mode 11 behaves as four counts
        @(negedge clk) cfg_mode = 2'b11;
        do_clr();
        go(4, 1'b1, 3);
        read_pos(v);
        chk("R6 mode 11 four counts", v, 32'd4);

        // R7 clear with the input parked on another phase
        go(1, 1'b1, 4);
        do_clr();
        go(2, 1'b1, 3);
        read_pos(v);
        chk("R7 tracking loaded on clear", v, 32'd2);

        settle();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule